// File: doc/BRIEF.md
# Single-Error-Correcting (7,4) Cyclic Codec

This block protects 4-bit messages with a systematic cyclic code of length 7 built on the generator g(x) = x^3 + x + 1, using modulo-2 arithmetic throughout. The encoder takes a message through a valid/ready handshake. A serial three-stage division register computes the three check bits over four clocks and then streams them out over three more clocks. A parallel XOR network computes the same check bits in one step, and the two results must match. When the stream ends, the full codeword is presented with a one-cycle done pulse.

The decoder accepts a 7-bit received word. It divides the word by g(x) to form a 3-bit syndrome. A nonzero syndrome is looked up against the seven single-bit error residues. The bit that matches is inverted in the data field, and the decoder reports the syndrome, an error flag and the bit position it corrected. The decoder registers its result once and accepts a new word every cycle.

Top module: `cyc74_codec`

## Requirements
- R1: Codeword bit i is the coefficient of x^i. Message bit j sits at codeword bit j+3. Codeword bits 2..0 are the remainder of m(x)·x^3 divided by x^3+x+1, for example message 4'b0111 gives codeword 7'b0111010 and message 4'b1011 gives 7'b1011000.
- R2: The check bits from the serial division register equal the check bits from the parallel XOR network for every message, and enc_cw carries them.
- R3: After reset enc_ready is high. A message is taken on a clock edge where enc_valid and enc_ready are both high, and enc_ready then stays low until the codeword is complete.
- R4: Counting the accepting edge as edge 0, enc_par_vld is high after edges 4, 5 and 6. It carries check bits 2, 1 and 0 in that order on enc_par_bit. enc_done is high for exactly one cycle after edge 7, together with the codeword on enc_cw.
- R5: The decoder output is registered. dec_out_valid is high in the cycle after dec_valid was sampled high, and low otherwise.
- R6: A received word that is a valid codeword gives dec_syn = 3'b000, dec_err = 0, dec_pos = 0 and dec_data equal to word bits 6..3.
- R7: A word with a single flipped bit at position i gives dec_syn equal to x^i mod g(x) (position 6 gives 3'b101, position 4 gives 3'b110), dec_err = 1, dec_pos = i, and dec_data equal to the original message.
- R8: enc_valid and enc_msg are ignored while enc_ready is low, so the codeword produced is that of the accepted message.
- R9: During reset enc_ready = 1, and enc_done, enc_par_vld and dec_out_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_valid | input | 1 | Message offered |
| enc_ready | output | 1 | Encoder idle, message can be taken |
| enc_msg | input | 4 | Message, bit j weights x^(j+3) |
| enc_cw | output | 7 | Codeword, valid while enc_done is high |
| enc_done | output | 1 | One-cycle pulse when the codeword is complete |
| enc_par_bit | output | 1 | Serial check bit, highest degree first |
| enc_par_vld | output | 1 | enc_par_bit is valid |
| dec_valid | input | 1 | Received word present |
| dec_word | input | 7 | Received word, bit i weights x^i |
| dec_out_valid | output | 1 | Decoder result valid |
| dec_data | output | 4 | Corrected message bits |
| dec_syn | output | 3 | Syndrome of the received word |
| dec_err | output | 1 | Nonzero syndrome, one bit corrected |
| dec_pos | output | 3 | Corrected bit position, 0 when no error |

## Verification
The hardest case to reach from the ports is a message offered while the serial encoder is busy. The port gives no sign of it, and a wrong design would corrupt the codeword only three to seven cycles later. The bench holds enc_valid high with a different message right after acceptance and compares the finished codeword and the streamed check bits with those of the first message. The decoder is driven with every codeword, both clean and with each of the seven single flips. Random words are added, and their expected correction is found by searching for the flip that makes the word divisible by g(x). This method does not use a syndrome table.

// File: rtl/cyc74_pkg.sv
package cyc74_pkg;
  localparam int MSG_K = 4;
  localparam int PAR_R = 3;
  localparam int CW_N  = MSG_K + PAR_R;
  localparam int POS_W = $clog2(CW_N);
  localparam int CNT_W = $clog2(MSG_K);
  localparam logic [PAR_R:0] GEN_POLY = 4'b1011;  // x^3 + x + 1

  typedef logic [MSG_K-1:0] msg_t;
  typedef logic [PAR_R-1:0] rem_t;
  typedef logic [CW_N-1:0]  cw_t;
  typedef logic [POS_W-1:0] pos_t;

  // residue of x^k modulo the generator
  function automatic rem_t xk_mod(input int k);
    rem_t r;
    logic top;
    r = rem_t'(1);
    for (int i = 0; i < CW_N; i++) begin
      if (i < k) begin
        top = r[PAR_R-1];
        r   = {r[PAR_R-2:0], 1'b0} ^ (top ? GEN_POLY[PAR_R-1:0] : '0);
      end
    end
    return r;
  endfunction

  // remainder of a whole word modulo the generator
  function automatic rem_t word_mod(input cw_t w);
    rem_t acc;
    acc = '0;
    for (int i = 0; i < CW_N; i++)
      if (w[i]) acc = acc ^ xk_mod(i);
    return acc;
  endfunction

  // which message bits feed check bit j
  function automatic msg_t par_mask(input int j);
    msg_t m;
    for (int i = 0; i < MSG_K; i++) begin
      rem_t t;
      t    = xk_mod(i + PAR_R);
      m[i] = t[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/cyc74_lfsr_div.sv
module cyc74_lfsr_div
  import cyc74_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift_en,
  input  logic din,
  output rem_t rem_nxt
);
  rem_t st;
  logic fb;

  assign fb = din ^ st[PAR_R-1];

  for (genvar j = 0; j < PAR_R; j++) begin : g_tap
    if (j == 0) begin : g_lo
      assign rem_nxt[j] = fb & GEN_POLY[j];
    end else begin : g_hi
      assign rem_nxt[j] = st[j-1] ^ (fb & GEN_POLY[j]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= '0;
    else if (clr)      st <= '0;
    else if (shift_en) st <= rem_nxt;
  end
endmodule

// File: rtl/cyc74_par_xor.sv
module cyc74_par_xor
  import cyc74_pkg::*;
(
  input  msg_t msg,
  output rem_t par
);
  for (genvar j = 0; j < PAR_R; j++) begin : g_eq
    localparam msg_t MASK = par_mask(j);
    assign par[j] = ^(msg & MASK);
  end
endmodule

// File: rtl/cyc74_enc.sv
module cyc74_enc
  import cyc74_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  msg_t in_msg,
  output cw_t  cw,
  output logic done,
  output logic par_bit,
  output logic par_vld,
  output logic par_load,
  output rem_t ser_par,
  output rem_t xor_par
);
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_OUT} enc_st_e;
  localparam int OCNT_W = $clog2(PAR_R);

  enc_st_e           st;
  msg_t              msg_q;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  idx;
  logic [OCNT_W-1:0] ocnt;
  rem_t              par_hold, out_sh;
  logic              done_q, take;

  assign in_ready = (st == ST_IDLE);
  assign take     = in_ready & in_valid;
  assign idx      = CNT_W'(MSG_K-1) - cnt;
  assign par_load = (st == ST_SHIFT) && (cnt == CNT_W'(MSG_K-1));

  cyc74_lfsr_div i_div (
    .clk(clk), .rst_n(rst_n), .clr(take),
    .shift_en(st == ST_SHIFT), .din(msg_q[idx]), .rem_nxt(ser_par)
  );

  cyc74_par_xor i_xor (.msg(msg_q), .par(xor_par));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      msg_q    <= '0;
      cnt      <= '0;
      ocnt     <= '0;
      par_hold <= '0;
      out_sh   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (take) begin
          msg_q <= in_msg;
          cnt   <= '0;
          st    <= ST_SHIFT;
        end
        ST_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (par_load) begin
            par_hold <= ser_par;
            out_sh   <= ser_par;
            ocnt     <= '0;
            st       <= ST_OUT;
          end
        end
        ST_OUT: begin
          out_sh <= {out_sh[PAR_R-2:0], 1'b0};
          ocnt   <= ocnt + 1'b1;
          if (ocnt == OCNT_W'(PAR_R-1)) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign par_vld = (st == ST_OUT);
  assign par_bit = out_sh[PAR_R-1];
  assign done    = done_q;
  assign cw      = {msg_q, par_hold};
endmodule

// File: rtl/cyc74_dec.sv
module cyc74_dec
  import cyc74_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  cw_t  word,
  output logic out_valid,
  output msg_t data,
  output rem_t syn,
  output logic err,
  output pos_t pos
);
  rem_t s_c;
  pos_t p_c;
  logic e_c;
  msg_t flip;

  assign s_c = word_mod(word);
  assign e_c = (s_c != '0);

  // syndrome to position table, one entry per nonzero syndrome
  always_comb begin
    p_c = '0;
    for (int i = 0; i < CW_N; i++)
      if (e_c && (xk_mod(i) == s_c)) p_c = pos_t'(i);
  end

  for (genvar j = 0; j < MSG_K; j++) begin : g_flip
    assign flip[j] = e_c && (p_c == pos_t'(j + PAR_R));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data      <= '0;
      syn       <= '0;
      err       <= 1'b0;
      pos       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        data <= word[CW_N-1:PAR_R] ^ flip;
        syn  <= s_c;
        err  <= e_c;
        pos  <= p_c;
      end
    end
  end
endmodule

// File: rtl/cyc74_codec.sv
module cyc74_codec
  import cyc74_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_valid,
  output logic       enc_ready,
  input  logic [3:0] enc_msg,
  output logic [6:0] enc_cw,
  output logic       enc_done,
  output logic       enc_par_bit,
  output logic       enc_par_vld,
  input  logic       dec_valid,
  input  logic [6:0] dec_word,
  output logic       dec_out_valid,
  output logic [3:0] dec_data,
  output logic [2:0] dec_syn,
  output logic       dec_err,
  output logic [2:0] dec_pos
);
  // named internal events for the checker
  logic par_load;
  rem_t ser_par, xor_par;

  cyc74_enc i_enc (
    .clk(clk), .rst_n(rst_n),
    .in_valid(enc_valid), .in_ready(enc_ready), .in_msg(enc_msg),
    .cw(enc_cw), .done(enc_done),
    .par_bit(enc_par_bit), .par_vld(enc_par_vld),
    .par_load(par_load), .ser_par(ser_par), .xor_par(xor_par)
  );

  cyc74_dec i_dec (
    .clk(clk), .rst_n(rst_n),
    .in_valid(dec_valid), .word(dec_word),
    .out_valid(dec_out_valid), .data(dec_data),
    .syn(dec_syn), .err(dec_err), .pos(dec_pos)
  );
endmodule

// File: rtl/cyc74_codec_chk.sv
module cyc74_codec_chk
  import cyc74_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       enc_valid,
  input logic       enc_ready,
  input logic       enc_done,
  input logic       enc_par_vld,
  input logic       dec_valid,
  input logic       dec_out_valid,
  input logic       dec_err,
  input logic [2:0] dec_syn,
  input logic [2:0] dec_pos,
  input logic       par_load,
  input logic [2:0] ser_par,
  input logic [2:0] xor_par
);
  a_r2_serial_eq_parallel: assert property (@(posedge clk) disable iff (!rst_n)
    par_load |-> ser_par == xor_par);

  a_r3_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid && enc_ready |=> !enc_ready);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    enc_done |=> !enc_done);

  a_r4_stream_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    enc_par_vld |-> !enc_ready);

  a_r5_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> dec_out_valid);

  a_r6_clean_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_err |-> dec_syn == 3'b000 && dec_pos == 3'd0);

  a_r7_pos_matches_syn: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && dec_err |-> xk_mod(int'(dec_pos)) == dec_syn);
endmodule

bind cyc74_codec cyc74_codec_chk i_chk (
  .clk(clk), .rst_n(rst_n),
  .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_done(enc_done),
  .enc_par_vld(enc_par_vld), .dec_valid(dec_valid),
  .dec_out_valid(dec_out_valid), .dec_err(dec_err), .dec_syn(dec_syn),
  .dec_pos(dec_pos), .par_load(par_load), .ser_par(ser_par), .xor_par(xor_par)
);

// File: tb/test_cyc74_codec.sv
module test_cyc74_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_valid = 1'b0;
  logic [3:0] enc_msg = '0;
  logic       dec_valid = 1'b0;
  logic [6:0] dec_word = '0;
  logic       enc_ready, enc_done, enc_par_bit, enc_par_vld;
  logic [6:0] enc_cw;
  logic       dec_out_valid, dec_err;
  logic [3:0] dec_data;
  logic [2:0] dec_syn, dec_pos;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  cyc74_codec i_cyc74_codec (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // long division, highest degree first
  function automatic logic [2:0] ref_rem(input logic [6:0] w);
    logic [6:0] t;
    t = w;
    for (int i = 6; i >= 3; i--)
      if (t[i]) t = t ^ (7'b0001011 << (i - 3));
    return t[2:0];
  endfunction

  function automatic logic [6:0] ref_enc(input logic [3:0] m);
    return {m, ref_rem({m, 3'b000})};
  endfunction

  // position whose flip makes the word divisible, 0 if already clean
  function automatic int ref_pos(input logic [6:0] w);
    int p;
    p = 0;
    for (int i = 0; i < 7; i++)
      if (ref_rem(w ^ (7'd1 << i)) == 3'b000) p = i;
    return p;
  endfunction

  task automatic enc_one(input logic [3:0] m, input bit poke);
    logic [2:0] bits;
    int nb, done_at;
    bits = '0; nb = 0; done_at = -1;
    @(negedge clk);
    chk(enc_ready == 1'b1, "R3 ready before take", enc_ready, 1);
    enc_valid = 1'b1; enc_msg = m;
    @(negedge clk);  // after edge 0
    if (poke) enc_msg = ~m; else enc_valid = 1'b0;
    chk(enc_ready == 1'b0, "R3 ready low after take", enc_ready, 0);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 2) enc_valid = 1'b0;
      if (enc_par_vld) begin
        if (k < 4 || k > 6) chk(0, "R4 par_vld cycle", k, 4);
        bits = {bits[1:0], enc_par_bit};
        nb++;
      end
      if (enc_done) begin
        done_at = k;
        chk(enc_cw == ref_enc(m), poke ? "R8 busy input ignored" : "R1 codeword",
            enc_cw, ref_enc(m));
        break;
      end
    end
    chk(done_at == 7, "R4 done latency", done_at, 7);
    chk(nb == 3 && bits == ref_rem({m, 3'b000}), "R2 serial parity stream",
        bits, ref_rem({m, 3'b000}));
    @(negedge clk);
    chk(enc_done == 1'b0 && enc_ready == 1'b1, "R4 done single pulse",
        {enc_done, enc_ready}, 1);
  endtask

  task automatic dec_one(input logic [6:0] w, input logic [3:0] exp_data, input string tag);
    int ep;
    logic [2:0] es;
    ep = ref_pos(w);
    es = ref_rem(w);
    @(negedge clk);
    dec_valid = 1'b1; dec_word = w;
    @(negedge clk);
    dec_valid = 1'b0;
    chk(dec_out_valid == 1'b1, "R5 out_valid", dec_out_valid, 1);
    chk(dec_syn == es, {tag, " syndrome"}, dec_syn, es);
    chk(dec_err == (es != 0), {tag, " err flag"}, dec_err, es != 0);
    chk(dec_pos == 3'(ep), {tag, " position"}, dec_pos, ep);
    chk(dec_data == exp_data, {tag, " data"}, dec_data, exp_data);
    @(negedge clk);
    chk(dec_out_valid == 1'b0, "R5 out_valid drops", dec_out_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int seed;
    logic [6:0] w;
    logic [3:0] m;
    seed = 17;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    chk(enc_ready == 1'b1 && enc_done == 1'b0 && enc_par_vld == 1'b0 &&
        dec_out_valid == 1'b0, "R9 reset state",
        {enc_ready, enc_done, enc_par_vld, dec_out_valid}, 4'b1000);
    rst_n = 1'b1;

    // directed examples
    chk(ref_enc(4'b0111) == 7'b0111010, "R1 model example 0111", ref_enc(4'b0111), 7'h3a);
    enc_one(4'b0111, 1'b0);
    enc_one(4'b1011, 1'b0);
    dec_one(7'b0111010 ^ 7'b1000000, 4'b0111, "R7 bit6 gives 101");
    chk(dec_syn == 3'b101, "R7 bit6 syndrome literal", dec_syn, 5);
    dec_one(7'b1011000 ^ 7'b0010000, 4'b1011, "R7 bit4 correction");
    chk(dec_syn == 3'b110, "R7 bit4 syndrome literal", dec_syn, 6);

    // R8 busy poke
    enc_one(4'b1001, 1'b1);
    enc_one(4'b0000, 1'b1);

    // every message through the encoder, clean and single-error decoding
    for (int mi = 0; mi < 16; mi++) begin
      enc_one(4'(mi), 1'b0);
      dec_one(ref_enc(4'(mi)), 4'(mi), "R6 clean word");
      for (int p = 0; p < 7; p++)
        dec_one(ref_enc(4'(mi)) ^ (7'd1 << p), 4'(mi), "R7 single flip");
    end

    // random received words
    for (int n = 0; n < 60; n++) begin
      w = 7'($urandom);
      m = w[6:3] ^ (ref_rem(w) != 0 && ref_pos(w) >= 3 ? 4'(1 << (ref_pos(w) - 3)) : 4'b0);
      dec_one(w, m, "R7 random word");
    end

    // back-to-back decoder words
    @(negedge clk);
    dec_valid = 1'b1; dec_word = ref_enc(4'hA) ^ 7'b0000100;
    @(negedge clk);
    dec_word = ref_enc(4'h5);
    chk(dec_data == 4'hA && dec_pos == 3'd2, "R5 back-to-back first", dec_data, 4'hA);
    @(negedge clk);
    dec_valid = 1'b0;
    chk(dec_data == 4'h5 && dec_err == 1'b0, "R6 back-to-back second", dec_data, 4'h5);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule